// File: doc/BRIEF.md
# Completion Interrupt Pending Controller

This block gathers transfer-completion notices for a set of channels (64 by default) into a pending register and combines it with a per-channel interrupt enable. It drives a single interrupt line to a processor. Each completion arrives as a valid strobe with a 6-bit channel code, and the matching pending bit is set. The pending bits are read as 32-bit words: bit k of word j belongs to channel 32·j + k.

Software uses a small write/read register interface. It reads the pending words, clears pending bits by writing ones, and turns enables on or off through separate write-one-to-set and write-one-to-clear locations. The interrupt output is a one-cycle pulse. A pulse is sent when the OR of the enabled pending bits rises from zero. If bits are still pending after the handler has run, software writes the evaluate location to get a fresh pulse.

A register address is `{kind[2:0], word}`, with `word` as the low bit. The kinds are: 0 pending read, 1 pending clear, 2 enable set, 3 enable clear, 4 evaluate. So, for example, address 3 clears pending word 1 and address 8 is the evaluate location.

Top module: `cip_ctrl`

## Requirements
- R1: After reset, both pending words, both enable words and `irq_o` are zero.
- R2: A cycle with `done_valid_i` high and `done_code_i` = c sets pending bit c. That bit is read as bit c%32 of the pending word at address c/32 (addresses 0 and 1).
- R3: Writing a word to pending-clear address 2+j clears each pending bit of word j where the data holds a 1. The other bits keep their values.
- R4: A completion for channel c in the same cycle as a pending-clear write that covers bit c leaves bit c set.
- R5: Writing to enable-set address 4+j sets the enable bits of word j where the data holds a 1. Writing to enable-clear address 6+j clears those bits. Reading address 4+j or 6+j returns enable word j.
- R6: Pending bits record completions whether or not their enable is on. A completion on a disabled channel produces no interrupt.
- R7: When the OR of (pending AND enable) goes from zero to non-zero, `irq_o` is high for exactly one cycle. That cycle is the one after the first cycle in which the new register state is visible.
- R8: A write to address 8 with data bit 0 set produces a one-cycle pulse on `irq_o` in the next cycle if any enabled pending bit is set at the time of the write. If none is set, or if data bit 0 is zero, the write produces no pulse.
- R9: Writes to the pending read addresses 0 and 1 change nothing.
- R10: While the OR of enabled pending bits stays non-zero, new completions or new enables produce no further pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| done_valid_i | input | 1 | Completion strobe |
| done_code_i | input | 6 | Channel number of the completion |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address {kind, word} |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 4 | Register read address {kind, word} |
| rd_data_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
Completions and register writes take effect in the state at the first clock edge after they are driven. The bench therefore reads the pending and enable words combinationally at the next falling edge. An enable or completion that makes the enabled OR rise gives its pulse one edge later than that, so the bench expects `irq_o` low at the first falling edge and high at the second. An evaluate write gives its pulse at the first falling edge. For every scenario where no pulse is allowed, the bench watches `irq_o` at each falling edge for several cycles.

// File: rtl/cip_pkg.sv
package cip_pkg;

    // Register kinds carried in the upper address bits
    typedef enum logic [2:0] {
        KIND_PEND_RD  = 3'd0,
        KIND_PEND_CLR = 3'd1,
        KIND_EN_SET   = 3'd2,
        KIND_EN_CLR   = 3'd3,
        KIND_EVAL     = 3'd4
    } reg_kind_e;

endpackage

// File: rtl/cip_bank.sv
module cip_bank
    import cip_pkg::*;
#(
    parameter int NUM_CH  = 64,
    parameter int WORD_W  = 32,
    parameter int CODE_W  = 6,
    parameter int NWORDS  = 2,
    parameter int WIDX_W  = 1,
    localparam int PAD_W  = NWORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_valid_i,
    input  logic [CODE_W-1:0] done_code_i,
    input  logic              wr_en_i,
    input  reg_kind_e         wr_kind_i,
    input  logic [WIDX_W-1:0] wr_word_i,
    input  logic [WORD_W-1:0] wr_data_i,
    output logic [PAD_W-1:0]  pend_o,
    output logic [PAD_W-1:0]  en_o
);

    typedef struct packed {
        logic [PAD_W-1:0] pend;
        logic [PAD_W-1:0] en;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int w = 0; w < NWORDS; w++) begin
            if (wr_en_i && (int'(wr_word_i) == w)) begin
                case (wr_kind_i)
                    KIND_PEND_CLR: st_d.pend[w*WORD_W +: WORD_W] = st_q.pend[w*WORD_W +: WORD_W] & ~wr_data_i;
                    KIND_EN_SET:   st_d.en[w*WORD_W +: WORD_W]   = st_q.en[w*WORD_W +: WORD_W] | wr_data_i;
                    KIND_EN_CLR:   st_d.en[w*WORD_W +: WORD_W]   = st_q.en[w*WORD_W +: WORD_W] & ~wr_data_i;
                    default: ;
                endcase
            end
        end
        // a completion in the same cycle as a clear keeps its bit set
        if (done_valid_i && (int'(done_code_i) < NUM_CH)) begin
            st_d.pend[done_code_i] = 1'b1;
        end
        // padding channels beyond NUM_CH never hold state
        for (int b = NUM_CH; b < PAD_W; b++) begin
            st_d.pend[b] = 1'b0;
            st_d.en[b]   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
    assign en_o   = st_q.en;

    // R2 / R4: a completion always leaves its bit set
    assert_done_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid_i && (int'(done_code_i) < NUM_CH)) |=> pend_o[$past(done_code_i)]);

    // R3: cleared bits are gone when no completion competes
    assert_clear_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_kind_i == KIND_PEND_CLR && !done_valid_i) |=>
        (((pend_o >> (int'($past(wr_word_i)) * WORD_W)) & PAD_W'($past(wr_data_i))) == '0));

    // R5: enable set makes the written ones visible
    assert_en_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_kind_i == KIND_EN_SET) |=>
        (((en_o >> (int'($past(wr_word_i)) * WORD_W)) & PAD_W'($past(wr_data_i)))
          == (PAD_W'($past(wr_data_i)) & (PAD_W'({NUM_CH{1'b1}}) >> (int'($past(wr_word_i)) * WORD_W)))));

endmodule

// File: rtl/cip_irq.sv
module cip_irq #(
    parameter int PAD_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PAD_W-1:0] pend_i,
    input  logic [PAD_W-1:0] en_i,
    input  logic             eval_i,
    output logic             irq_o
);

    typedef struct packed {
        logic any_prev;
        logic irq;
    } irq_t;

    irq_t st_d, st_q;
    logic any_now;

    always_comb begin
        any_now     = |(pend_i & en_i);
        st_d        = st_q;
        st_d.any_prev = any_now;
        st_d.irq    = (any_now && !st_q.any_prev) || (eval_i && any_now);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = st_q.irq;

    // R7: a rise of the enabled OR gives a pulse next cycle
    assert_rise_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (any_now && !st_q.any_prev) |=> irq_o);

    // R8: evaluate with work outstanding gives a pulse
    assert_eval_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_i && any_now) |=> irq_o);

    // R10: with the OR steady and no evaluate, the line stays low
    assert_steady_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!eval_i && any_now && st_q.any_prev) |=> !irq_o);

    // R6: nothing enabled and pending means no pulse
    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_now) |=> !irq_o);

endmodule

// File: rtl/cip_ctrl.sv
module cip_ctrl
    import cip_pkg::*;
#(
    parameter int NUM_CH = 64,
    parameter int WORD_W = 32,
    localparam int NWORDS = (NUM_CH + WORD_W - 1) / WORD_W,
    localparam int WIDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1,
    localparam int CODE_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W = 3 + WIDX_W,
    localparam int PAD_W  = NWORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_valid_i,
    input  logic [CODE_W-1:0] done_code_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [WORD_W-1:0] rd_data_o,
    output logic              irq_o
);

    reg_kind_e         wr_kind, rd_kind;
    logic [WIDX_W-1:0] wr_word, rd_word;
    logic [PAD_W-1:0]  pend, en;
    logic              eval_hit;

    assign wr_kind  = reg_kind_e'(wr_addr_i[ADDR_W-1 -: 3]);
    assign wr_word  = wr_addr_i[WIDX_W-1:0];
    assign rd_kind  = reg_kind_e'(rd_addr_i[ADDR_W-1 -: 3]);
    assign rd_word  = rd_addr_i[WIDX_W-1:0];
    assign eval_hit = wr_en_i && (wr_kind == KIND_EVAL) && wr_data_i[0];

    cip_bank #(
        .NUM_CH (NUM_CH),
        .WORD_W (WORD_W),
        .CODE_W (CODE_W),
        .NWORDS (NWORDS),
        .WIDX_W (WIDX_W)
    ) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .done_valid_i (done_valid_i),
        .done_code_i  (done_code_i),
        .wr_en_i      (wr_en_i),
        .wr_kind_i    (wr_kind),
        .wr_word_i    (wr_word),
        .wr_data_i    (wr_data_i),
        .pend_o       (pend),
        .en_o         (en)
    );

    cip_irq #(
        .PAD_W (PAD_W)
    ) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (pend),
        .en_i   (en),
        .eval_i (eval_hit),
        .irq_o  (irq_o)
    );

    always_comb begin
        rd_data_o = '0;
        for (int w = 0; w < NWORDS; w++) begin
            if (int'(rd_word) == w) begin
                case (rd_kind)
                    KIND_PEND_RD, KIND_PEND_CLR: rd_data_o = pend[w*WORD_W +: WORD_W];
                    KIND_EN_SET, KIND_EN_CLR:    rd_data_o = en[w*WORD_W +: WORD_W];
                    default:                     rd_data_o = '0;
                endcase
            end
        end
    end

    // R9: a write to a pending read address leaves pending untouched
    assert_pend_ro_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_kind == KIND_PEND_RD && !done_valid_i) |=> (pend == $past(pend)));

endmodule

// File: tb/cip_ctrl_tb.sv
module cip_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        done_valid;
    logic [5:0]  done_code;
    logic        wr_en;
    logic [3:0]  wr_addr;
    logic [31:0] wr_data;
    logic [3:0]  rd_addr;
    logic [31:0] rd_data;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    cip_ctrl u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .done_valid_i (done_valid),
        .done_code_i  (done_code),
        .wr_en_i      (wr_en),
        .wr_addr_i    (wr_addr),
        .wr_data_i    (wr_data),
        .rd_addr_i    (rd_addr),
        .rd_data_o    (rd_data),
        .irq_o        (irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic read_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
        rd_addr = a;
        #1;
        chk(tag, rd_data, exp);
    endtask

    // drive one cycle of stimulus starting at a falling edge
    task automatic step(input logic dv, input logic [5:0] code,
                        input logic we, input logic [3:0] a, input logic [31:0] d);
        done_valid = dv; done_code = code;
        wr_en = we; wr_addr = a; wr_data = d;
        @(negedge clk);
        done_valid = 1'b0; wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic quiet_irq(input string tag, input int n);
        for (int i = 0; i < n; i++) begin
            chk(tag, {31'd0, irq}, 32'd0);
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        read_chk("R1 pend0", 4'd0, 32'd0);
        read_chk("R1 pend1", 4'd1, 32'd0);
        read_chk("R1 en0",   4'd4, 32'd0);
        read_chk("R1 en1",   4'd5, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_capture;
        step(1'b1, 6'd5, 1'b0, 4'd0, 32'd0);
        read_chk("R2 ch5 in word0", 4'd0, 32'h0000_0020);
        quiet_irq("R6 disabled no irq", 3);
        step(1'b1, 6'd40, 1'b0, 4'd0, 32'd0);
        read_chk("R2 ch40 in word1 bit8", 4'd1, 32'h0000_0100);
        read_chk("R2 word0 kept", 4'd0, 32'h0000_0020);
    endtask

    task automatic t_read_only;
        step(1'b0, 6'd0, 1'b1, 4'd0, 32'hFFFF_FFFF);
        read_chk("R9 pend0 unchanged", 4'd0, 32'h0000_0020);
        step(1'b0, 6'd0, 1'b1, 4'd1, 32'h0000_0000);
        read_chk("R9 pend1 unchanged", 4'd1, 32'h0000_0100);
    endtask

    task automatic t_clear;
        step(1'b0, 6'd0, 1'b1, 4'd2, 32'h0000_0020);
        read_chk("R3 pend0 cleared", 4'd0, 32'd0);
        read_chk("R3 pend1 untouched", 4'd1, 32'h0000_0100);
    endtask

    task automatic t_enable_rise;
        step(1'b0, 6'd0, 1'b1, 4'd5, 32'h0000_0100);
        read_chk("R5 en1 set", 4'd5, 32'h0000_0100);
        chk("R7 irq not yet", {31'd0, irq}, 32'd0);
        @(negedge clk);
        chk("R7 irq pulse", {31'd0, irq}, 32'd1);
        @(negedge clk);
        chk("R7 pulse one cycle", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_no_repulse;
        step(1'b0, 6'd0, 1'b1, 4'd4, 32'h0000_0008);
        read_chk("R5 en0 set", 4'd6, 32'h0000_0008);
        step(1'b1, 6'd3, 1'b0, 4'd0, 32'd0);
        quiet_irq("R10 no second pulse", 4);
    endtask

    task automatic t_eval;
        step(1'b0, 6'd0, 1'b1, 4'd8, 32'h0000_0001);
        chk("R8 eval pulse", {31'd0, irq}, 32'd1);
        @(negedge clk);
        chk("R8 eval pulse one cycle", {31'd0, irq}, 32'd0);
        step(1'b0, 6'd0, 1'b1, 4'd8, 32'h0000_0002);
        quiet_irq("R8 eval bit0 zero", 2);
    endtask

    task automatic t_race;
        step(1'b1, 6'd3, 1'b1, 4'd2, 32'h0000_0008);
        read_chk("R4 set wins", 4'd0, 32'h0000_0008);
        step(1'b0, 6'd0, 1'b1, 4'd2, 32'hFFFF_FFFF);
        step(1'b0, 6'd0, 1'b1, 4'd3, 32'hFFFF_FFFF);
        read_chk("R3 all clear w0", 4'd0, 32'd0);
        read_chk("R3 all clear w1", 4'd1, 32'd0);
        step(1'b0, 6'd0, 1'b1, 4'd8, 32'h0000_0001);
        quiet_irq("R8 eval nothing pending", 2);
    endtask

    task automatic t_disable;
        step(1'b0, 6'd0, 1'b1, 4'd7, 32'h0000_0100);
        read_chk("R5 en1 cleared", 4'd7, 32'd0);
        read_chk("R5 en0 kept", 4'd4, 32'h0000_0008);
        step(1'b1, 6'd40, 1'b0, 4'd0, 32'd0);
        read_chk("R6 ch40 recorded", 4'd1, 32'h0000_0100);
        quiet_irq("R6 disabled ch40 no irq", 3);
        step(1'b1, 6'd3, 1'b0, 4'd0, 32'd0);
        chk("R7 completion rise not yet", {31'd0, irq}, 32'd0);
        @(negedge clk);
        chk("R7 completion rise pulse", {31'd0, irq}, 32'd1);
        @(negedge clk);
        chk("R7 completion pulse ends", {31'd0, irq}, 32'd0);
    endtask

    initial begin
        rst_n = 1'b0; done_valid = 1'b0; done_code = '0;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_capture();
        t_read_only();
        t_clear();
        t_enable_rise();
        t_no_repulse();
        t_eval();
        t_race();
        t_disable();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule